// File: doc/BRIEF.md
# Physical Memory Protection Guard with Machine Lockdown Controls

This block decides, in the same cycle, whether a memory access may proceed. Each access is described by its byte address, its kind (read, write or execute) and the privilege level of the requester. The answer comes from sixteen protection entries, each holding a configuration byte and an address word. An entry matches by top-of-range, by a single naturally aligned word, or by a naturally aligned power-of-two region. Software programs the entries through one-register-at-a-time CSR writes. Four configuration CSRs hold four entry bytes each, and sixteen address CSRs hold one address each.

A security configuration CSR adds three control bits. The first is a lockdown bit. It reinterprets every entry's lock and permission bits as machine-only, user-only or shared rules. The second is a whitelist bit, which denies machine accesses that match no entry. The third is a bypass bit, which lets machine software rewrite locked entries until it is cleared. The lockdown and whitelist bits can only be set. The bypass bit can only be cleared. Every write to any of these protection CSRs raises a one-cycle flush pulse, so that a translation cache next to the block can drop cached permissions.

Top module: `pmp_guard`

## Requirements
- R1: After reset, every entry is off, MML=0, MMWP=0 and RLB=1, `tlb_flush` is low, and an access of type 0, 1 or 2 at any privilege is allowed.
- R2: The security CSR is at address 0x747, with bit 0 = MML, bit 1 = MMWP and bit 2 = RLB. Writing 1 to bit 0 or bit 1 sets that bit. Writing 0 never clears either of them before reset.
- R3: Writing 0 to bit 2 of 0x747 clears RLB. Any later write of 1 to bit 2 leaves RLB at 0, so locked entries stay protected.
- R4: `tlb_flush` is high for exactly the one cycle after each cycle in which `csr_we` targets 0x747, 0x3A0..0x3A3 or 0x3B0..0x3BF. This holds whether or not the write was ignored. A write to any other address gives no pulse.
- R5: CSR 0x3A0+k holds entries 4k..4k+3, with entry 4k+j in bits 8j+7..8j. In each byte, bit 0 = R, bit 1 = W, bit 2 = X, bits 4:3 = mode (0 off, 1 TOR, 2 NA4, 3 NAPOT) and bit 7 = L. Bits 6:5 are stored as 0. CSR 0x3B0+i holds byte-address bits 31:2 of entry i. The match rules, with W meaning the word address of the access, are:
  - TOR: previous entry's address <= W < own address. For entry 0 the lower bound is 0.
  - NA4: W equals the entry's address.
  - NAPOT: when the address has t trailing ones, the entry covers the aligned block of 2^(t+1) words that contains it.
- R6: When several entries match, the lowest-numbered one alone decides the result.
- R7: The access type codes are 0 = read, 1 = write, 2 = execute, and they require R, W and X respectively. Type 3 is denied in every case. Privilege code 3 is machine and every other code is S/U. With MML=0, a matching entry with L=0 allows every machine access of type 0..2. Otherwise the access is allowed only when the entry has the bit that its type requires.
- R8: An access that matches no entry is treated as follows:
  - Machine access: allowed exactly when MMWP=0.
  - S/U access: allowed only when no entry has a nonzero mode.
- R9: With MML=1, the matching entry's {L,R,W,X} decides, and X means any type 0..2:

  | {L,R,W,X} | Machine may | S/U may |
  |---|---|---|
  | 0010 | read, write | read |
  | 0011 | read, write | read, write |
  | 1010 | execute | execute |
  | 1011 | read, execute | execute |
  | 1111 | read | read |
  | other, L=0 | nothing | its R/W/X |
  | other, L=1 | its R/W/X | nothing |
- R10: While RLB=0, a write is ignored in these cases:
  - a configuration byte whose L bit is set;
  - an address register whose own entry is locked;
  - an address register whose next entry is locked in TOR mode.

  While RLB=1, all of these writes take effect.
- R11: An access presented in the same cycle as a CSR write is judged by the configuration before the write. The write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR number being written |
| csr_wdata | input | CSR_W | CSR write data |
| acc_addr | input | ADDR_W | Byte address of the access being checked |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_priv | input | 2 | 3 machine, otherwise supervisor/user |
| acc_allow | output | 1 | 1 when the access is permitted (combinational) |
| tlb_flush | output | 1 | One-cycle pulse after each protection CSR write |

## Verification
The permission check and a configuration update can fall in the same cycle. The combinational verdict must then use the old entries, while the flush pulse and the new state appear one edge later. The bench provokes this on every constrained random cycle. It drives a random access alongside a write that is randomly present, checks `acc_allow` before the edge against its model's pre-write state, and only then applies the write to the model and checks the flush one cycle later. Directed cases arrange lock-protected writes and lockdown reinterpretation so that an ignored write would flip a verdict.

// File: rtl/pmpg_pkg.sv
package pmpg_pkg;

  localparam logic [11:0] SEC_CSR  = 12'h747;
  localparam logic [11:0] CFG_CSR0 = 12'h3A0;
  localparam logic [11:0] ADR_CSR0 = 12'h3B0;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  localparam int B_R = 0;
  localparam int B_W = 1;
  localparam int B_X = 2;
  localparam int B_L = 7;

  // Lockdown permission table: returns {x,w,r} for the requesting side.
  function automatic logic [2:0] lockdown_perm(input logic [7:0] c, input logic for_m);
    logic [2:0] m_p, u_p;
    logic l;
    l = c[B_L];
    if (!c[B_R] && c[B_W]) begin
      if (!l) begin
        m_p = 3'b011;
        u_p = c[B_X] ? 3'b011 : 3'b001;
      end else begin
        m_p = c[B_X] ? 3'b101 : 3'b100;
        u_p = 3'b100;
      end
    end else if (l && c[B_R] && c[B_W] && c[B_X]) begin
      m_p = 3'b001;
      u_p = 3'b001;
    end else if (l) begin
      m_p = c[2:0];
      u_p = 3'b000;
    end else begin
      m_p = 3'b000;
      u_p = c[2:0];
    end
    return for_m ? m_p : u_p;
  endfunction

  function automatic logic type_ok(input logic [2:0] p, input logic [1:0] t);
    return (t == 2'd3) ? 1'b0 : p[t];
  endfunction

endpackage

// File: rtl/pmpg_seccfg.sv
module pmpg_seccfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wbits,
  output logic       mml,
  output logic       mmwp,
  output logic       rlb
);
  logic mml_q, mmwp_q, rlb_q;
  logic mml_d, mmwp_d, rlb_d;

  always_comb begin
    mml_d  = mml_q  | wbits[0];
    mmwp_d = mmwp_q | wbits[1];
    rlb_d  = rlb_q  & wbits[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mml_q  <= 1'b0;
      mmwp_q <= 1'b0;
      rlb_q  <= 1'b1;
    end else if (wr_en) begin
      mml_q  <= mml_d;
      mmwp_q <= mmwp_d;
      rlb_q  <= rlb_d;
    end
  end

  assign mml  = mml_q;
  assign mmwp = mmwp_q;
  assign rlb  = rlb_q;
endmodule

// File: rtl/pmpg_regs.sv
module pmpg_regs
  import pmpg_pkg::*;
#(
  parameter int N     = 16,
  parameter int WA_W  = 30,
  parameter int CSR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [11:0]              wr_addr,
  input  logic [CSR_W-1:0]         wr_data,
  input  logic                     rlb,
  output logic [N-1:0][7:0]        cfg,
  output logic [N-1:0][WA_W-1:0]   pa
);
  localparam int BPR = CSR_W / 8;

  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam int REG  = i / BPR;
    localparam int LANE = i % BPR;
    logic [7:0]      c_q, c_d;
    logic [WA_W-1:0] a_q, a_d;
    logic            c_we, a_we, tor_lock;

    if (i < N - 1) begin : g_nb
      assign tor_lock = cfg[i+1][B_L] && (cfg[i+1][4:3] == AM_TOR);
    end else begin : g_last
      assign tor_lock = 1'b0;
    end

    assign c_we = wr_en && (wr_addr == CFG_CSR0 + 12'(REG)) && (rlb || !c_q[B_L]);
    assign a_we = wr_en && (wr_addr == ADR_CSR0 + 12'(i)) && (rlb || !(c_q[B_L] || tor_lock));

    always_comb begin
      c_d = {wr_data[LANE*8+7], 2'b00, wr_data[LANE*8 +: 5]};
      a_d = wr_data[WA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
      end else if (c_we) begin
        c_q <= c_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
      end else if (a_we) begin
        a_q <= a_d;
      end
    end

    assign cfg[i] = c_q;
    assign pa[i]  = a_q;
  end
endmodule

// File: rtl/pmpg_match.sv
module pmpg_match
  import pmpg_pkg::*;
#(
  parameter int N    = 16,
  parameter int WA_W = 30
) (
  input  logic [N-1:0][7:0]      cfg,
  input  logic [N-1:0][WA_W-1:0] pa,
  input  logic [WA_W-1:0]        wa,
  output logic [N-1:0]           hit
);
  localparam logic [WA_W-1:0] ONE = WA_W'(1);

  for (genvar i = 0; i < N; i++) begin : g_m
    logic [WA_W-1:0] lo, care;
    logic            in_tor, in_na4, in_napot;

    if (i == 0) begin : g_first
      assign lo = '0;
    end else begin : g_rest
      assign lo = pa[i-1];
    end

    assign care     = ~(pa[i] ^ (pa[i] + ONE));
    assign in_tor   = (wa >= lo) && (wa < pa[i]);
    assign in_na4   = (wa == pa[i]);
    assign in_napot = ((wa & care) == (pa[i] & care));

    always_comb begin
      case (cfg[i][4:3])
        AM_TOR:   hit[i] = in_tor;
        AM_NA4:   hit[i] = in_na4;
        AM_NAPOT: hit[i] = in_napot;
        default:  hit[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
  import pmpg_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  parameter int CSR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [CSR_W-1:0]  csr_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_type,
  input  logic [1:0]        acc_priv,
  output logic              acc_allow,
  output logic              tlb_flush
);
  localparam int WA_W     = ADDR_W - 2;
  localparam int CFG_REGS = N_ENT / (CSR_W / 8);
  localparam int IDX_W    = $clog2(N_ENT);

  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic                       sec_mml, sec_mmwp, sec_rlb, sec_we;
  logic [N_ENT-1:0][7:0]      cfg_w;
  logic [N_ENT-1:0][WA_W-1:0] pa_w;
  logic [N_ENT-1:0]           hit_w;

  assign sec_we = csr_we && (csr_addr == SEC_CSR);

  pmpg_seccfg u_sec (
    .clk(clk), .rst_n(rst_i_n), .wr_en(sec_we), .wbits(csr_wdata[2:0]),
    .mml(sec_mml), .mmwp(sec_mmwp), .rlb(sec_rlb)
  );

  pmpg_regs #(.N(N_ENT), .WA_W(WA_W), .CSR_W(CSR_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(csr_we), .wr_addr(csr_addr),
    .wr_data(csr_wdata), .rlb(sec_rlb), .cfg(cfg_w), .pa(pa_w)
  );

  pmpg_match #(.N(N_ENT), .WA_W(WA_W)) u_match (
    .cfg(cfg_w), .pa(pa_w), .wa(acc_addr[ADDR_W-1:2]), .hit(hit_w)
  );

  // Flush pulse
  logic prot_sel, flush_d, flush_q;
  assign prot_sel = (csr_addr == SEC_CSR)
                 || (csr_addr >= CFG_CSR0 && csr_addr < CFG_CSR0 + 12'(CFG_REGS))
                 || (csr_addr >= ADR_CSR0 && csr_addr < ADR_CSR0 + 12'(N_ENT));
  assign flush_d  = csr_we && prot_sel;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) flush_q <= 1'b0;
    else          flush_q <= flush_d;
  end
  assign tlb_flush = flush_q;

  // Priority decision
  logic [IDX_W-1:0] sel;
  logic             found, any_on, is_m, verdict;
  logic [7:0]       ent;

  always_comb begin
    sel    = '0;
    found  = 1'b0;
    any_on = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_w[i]) begin
        sel   = IDX_W'(i);
        found = 1'b1;
      end
      if (cfg_w[i][4:3] != AM_OFF) any_on = 1'b1;
    end
    ent  = cfg_w[sel];
    is_m = (acc_priv == 2'b11);
    if (!found)                   verdict = is_m ? !sec_mmwp : !any_on;
    else if (sec_mml)             verdict = type_ok(lockdown_perm(ent, is_m), acc_type);
    else if (is_m && !ent[B_L])   verdict = 1'b1;
    else                          verdict = type_ok(ent[2:0], acc_type);
  end

  assign acc_allow = verdict && (acc_type != 2'd3);

endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk #(
  parameter int N        = 16,
  parameter int CFG_REGS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic [11:0]       csr_addr,
  input logic              flush,
  input logic              mml,
  input logic              mmwp,
  input logic              rlb,
  input logic [N-1:0][7:0] cfg
);
  logic prot_hit;
  assign prot_hit = (csr_addr == 12'h747)
                 || ((csr_addr >= 12'h3A0) && (csr_addr <= 12'h3A0 + 12'(CFG_REGS - 1)))
                 || ((csr_addr >= 12'h3B0) && (csr_addr <= 12'h3B0 + 12'(N - 1)));

  AST_MML_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mml |=> mml); // R2
  AST_MMWP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mmwp |=> mmwp); // R2
  AST_RLB_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    !rlb |=> !rlb); // R3
  AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && prot_hit) |=> flush); // R4
  AST_FLUSH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(csr_we && prot_hit)); // R4

  for (genvar i = 0; i < N; i++) begin : g_lk
    AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rlb && cfg[i][7]) |=> $stable(cfg[i])); // R10
  end
endmodule

bind pmp_guard pmp_guard_chk #(.N(N_ENT), .CFG_REGS(CFG_REGS)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .csr_we(csr_we), .csr_addr(csr_addr),
  .flush(tlb_flush), .mml(sec_mml), .mmwp(sec_mmwp), .rlb(sec_rlb), .cfg(cfg_w)
);

// File: tb/tb_pmp_guard.sv
`timescale 1ns/100ps
module tb_pmp_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] acc_addr;
  logic [1:0]  acc_type, acc_priv;
  logic        acc_allow, tlb_flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pmp_guard dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .acc_addr(acc_addr), .acc_type(acc_type),
    .acc_priv(acc_priv), .acc_allow(acc_allow), .tlb_flush(tlb_flush)
  );

  // Bench model of the programmable state
  logic [7:0]  m_cfg  [16];
  logic [29:0] m_addr [16];
  logic m_mml, m_mmwp, m_rlb;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit perm_bit(input logic [7:0] c, input logic [1:0] t);
    case (t)
      2'd0: return c[0];
      2'd1: return c[1];
      2'd2: return c[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_match(input int i, input logic [29:0] wa);
    longint lo, hi, w, a;
    int t;
    w = longint'(wa);
    a = longint'(m_addr[i]);
    lo = (i == 0) ? 0 : longint'(m_addr[i-1]);
    case (m_cfg[i][4:3])
      2'd1: return (w >= lo) && (w < a);
      2'd2: return w == a;
      2'd3: begin
        t = 0;
        while (t < 30 && m_addr[i][t]) t++;
        hi = a >> (t + 1);
        return (w >> (t + 1)) == hi;
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit lockdown_ok(input logic [7:0] c, input logic [1:0] t, input bit is_m);
    bit m, u;
    case ({c[7], c[0], c[1], c[2]})
      4'b0010: begin m = (t <= 1); u = (t == 0); end
      4'b0011: begin m = (t <= 1); u = (t <= 1); end
      4'b1010: begin m = (t == 2); u = (t == 2); end
      4'b1011: begin m = (t == 0 || t == 2); u = (t == 2); end
      4'b1111: begin m = (t == 0); u = (t == 0); end
      default: begin
        m = c[7] ? perm_bit(c, t) : 1'b0;
        u = c[7] ? 1'b0 : perm_bit(c, t);
      end
    endcase
    return is_m ? m : u;
  endfunction

  function automatic bit model_allow(input logic [31:0] a, input logic [1:0] t, input logic [1:0] p);
    bit is_m, active;
    is_m = (p == 2'd3);
    if (t == 2'd3) return 1'b0;
    active = 1'b0;
    for (int i = 0; i < 16; i++) if (m_cfg[i][4:3] != 2'd0) active = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (m_match(i, a[31:2])) begin
        if (m_mml) return lockdown_ok(m_cfg[i], t, is_m);
        if (is_m && !m_cfg[i][7]) return 1'b1;
        return perm_bit(m_cfg[i], t);
      end
    end
    return is_m ? !m_mmwp : !active;
  endfunction

  function automatic bit is_prot(input logic [11:0] a);
    return (a == 12'h747) || (a >= 12'h3A0 && a <= 12'h3A3) || (a >= 12'h3B0 && a <= 12'h3BF);
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    bit lk;
    if (a == 12'h747) begin
      m_mml  = m_mml | d[0];
      m_mmwp = m_mmwp | d[1];
      m_rlb  = m_rlb & d[2];
    end else if (a >= 12'h3A0 && a <= 12'h3A3) begin
      for (int j = 0; j < 4; j++) begin
        int i;
        i = int'(a - 12'h3A0) * 4 + j;
        if (m_rlb || !m_cfg[i][7]) m_cfg[i] = {d[8*j+7], 2'b00, d[8*j +: 5]};
      end
    end else if (a >= 12'h3B0 && a <= 12'h3BF) begin
      int i;
      i = int'(a - 12'h3B0);
      lk = m_cfg[i][7] || (i < 15 && m_cfg[i+1][7] && m_cfg[i+1][4:3] == 2'd1);
      if (m_rlb || !lk) m_addr[i] = d[29:0];
    end
  endtask

  // One cycle: optional write plus access, access judged before the edge.
  task automatic cyc(input bit we, input logic [11:0] a, input logic [31:0] d,
                     input logic [31:0] aa, input logic [1:0] t, input logic [1:0] p,
                     input string tag, input bit chk_acc);
    bit exp_allow, exp_fl;
    csr_we = we; csr_addr = a; csr_wdata = d;
    acc_addr = aa; acc_type = t; acc_priv = p;
    #1;
    exp_allow = model_allow(aa, t, p);
    if (chk_acc) chk(tag, 32'(acc_allow), 32'(exp_allow));
    @(posedge clk);
    if (we) model_write(a, d);
    exp_fl = we && is_prot(a);
    @(negedge clk);
    chk("R4 flush", 32'(tlb_flush), 32'(exp_fl));
    csr_we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 32'h0, 2'd0, 2'd3, "", 1'b0);
  endtask

  task automatic ac(input logic [31:0] aa, input logic [1:0] t, input logic [1:0] p,
                    input string tag, input bit exp);
    acc_addr = aa; acc_type = t; acc_priv = p;
    #1;
    chk(tag, 32'(acc_allow), 32'(exp));
    chk({tag, " model"}, 32'(model_allow(aa, t, p)), 32'(exp));
    @(negedge clk);
  endtask

  task automatic rand_phase(input int n, input bit allow_sec);
    for (int k = 0; k < n; k++) begin
      bit we;
      int r;
      logic [11:0] a;
      logic [31:0] d;
      we = ($urandom % 10) < 4;
      r  = $urandom % 21;
      if (r < 4)       begin a = 12'h3A0 + 12'(r);   d = $urandom; end
      else if (r < 20) begin a = 12'h3B0 + 12'(r-4); d = $urandom % 64; end
      else             begin a = allow_sec ? 12'h747 : 12'h3C0; d = $urandom; end
      cyc(we, a, d, $urandom % 256, 2'($urandom % 4), 2'($urandom % 4), "R6 R11 random", 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i < 16; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
    m_mml = 0; m_mmwp = 0; m_rlb = 1;
    rst_n = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
    acc_addr = '0; acc_type = '0; acc_priv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 flush low", 32'(tlb_flush), 32'd0);
    ac(32'h40, 2'd0, 2'd0, "R1 user read", 1'b1);
    ac(32'h1234, 2'd2, 2'd3, "R1 machine exec", 1'b1);
    ac(32'h10, 2'd3, 2'd3, "R7 reserved type", 1'b0);

    // Random mix with bypass available, lockdown off
    rand_phase(400, 1'b0);
    for (int k = 0; k < 4; k++)  wr(12'h3A0 + 12'(k), 32'h0);
    for (int k = 0; k < 16; k++) wr(12'h3B0 + 12'(k), 32'h0);

    // Directed setup: e0 NA4 R @4, e1 locked TOR X [4,8), e2 locked NAPOT W words 16..23
    wr(12'h3B0, 32'd4); wr(12'h3B1, 32'd8); wr(12'h3B2, 32'd19);
    wr(12'h3A0, 32'h009A8C11);
    ac(32'd16, 2'd0, 2'd0, "R5 NA4 read", 1'b1);
    ac(32'd16, 2'd1, 2'd0, "R7 user lacks W", 1'b0);
    ac(32'd16, 2'd1, 2'd3, "R7 machine bypass", 1'b1);
    ac(32'd12, 2'd0, 2'd1, "R8 user unmatched", 1'b0);
    ac(32'd12, 2'd0, 2'd3, "R8 machine unmatched", 1'b1);
    ac(32'd16, 2'd2, 2'd0, "R6 lowest entry wins", 1'b0);
    ac(32'd20, 2'd2, 2'd0, "R5 TOR inside", 1'b1);
    ac(32'd32, 2'd2, 2'd0, "R5 TOR top exclusive", 1'b0);
    ac(32'd20, 2'd0, 2'd3, "R7 locked applies to machine", 1'b0);
    ac(32'd68, 2'd1, 2'd3, "R5 NAPOT write", 1'b1);
    ac(32'd92, 2'd0, 2'd3, "R5 NAPOT locked no R", 1'b0);
    ac(32'd96, 2'd1, 2'd1, "R5 NAPOT beyond end", 1'b0);

    // Clear bypass, then try to disturb locked state
    wr(12'h747, 32'h0);
    wr(12'h3A0, 32'h0);
    ac(32'd20, 2'd0, 2'd3, "R10 locked cfg kept", 1'b0);
    wr(12'h3B0, 32'd100);
    ac(32'd16, 2'd2, 2'd0, "R10 TOR base kept", 1'b1);
    wr(12'h3B2, 32'd63);
    ac(32'd200, 2'd0, 2'd3, "R10 locked addr kept", 1'b1);
    wr(12'h747, 32'h4);
    wr(12'h3A0, 32'h00000F00);
    ac(32'd20, 2'd0, 2'd3, "R3 bypass not re-armed", 1'b0);
    wr(12'h3C0, 32'hFFFF);
    wr(12'h3A4, 32'hFFFF);

    // Whitelist bit, sticky
    wr(12'h747, 32'h2);
    ac(32'd400, 2'd0, 2'd3, "R8 whitelist denies", 1'b0);
    wr(12'h747, 32'h0);
    ac(32'd400, 2'd0, 2'd3, "R2 whitelist sticky", 1'b0);

    // Lockdown
    wr(12'h747, 32'h1);
    ac(32'd20, 2'd2, 2'd3, "R9 machine-only exec", 1'b1);
    ac(32'd20, 2'd2, 2'd0, "R9 user denied machine rule", 1'b0);
    ac(32'd68, 2'd2, 2'd3, "R9 shared exec machine", 1'b1);
    ac(32'd68, 2'd2, 2'd1, "R9 shared exec user", 1'b1);
    ac(32'd68, 2'd1, 2'd3, "R9 shared exec no write", 1'b0);
    wr(12'h3B3, 32'd33);
    wr(12'h3A0, 32'h1A000011);
    wr(12'h747, 32'h0);
    ac(32'd16, 2'd0, 2'd3, "R9 user rule denies machine", 1'b0);
    ac(32'd16, 2'd0, 2'd0, "R9 user rule read", 1'b1);
    ac(32'd128, 2'd1, 2'd3, "R9 shared RW machine write", 1'b1);
    ac(32'd128, 2'd1, 2'd0, "R9 shared user no write", 1'b0);
    ac(32'd128, 2'd0, 2'd0, "R9 shared user read", 1'b1);
    ac(32'd20, 2'd2, 2'd3, "R2 lockdown sticky", 1'b1);

    // Random mix under lockdown and cleared bypass
    rand_phase(400, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule